// File: doc/BRIEF.md
# I2C Controller Interrupt Status Unit

This unit sits beside an I2C transaction engine and turns four engine conditions into sticky interrupt status bits. The events are: the receive FIFO being completely full, the receive occupancy climbing past a programmable threshold, the end of a transaction, and the transmit FIFO draining while a write still expects more bytes. Each event latches into a status word. Software clears a status bit by writing a 1 to it.

An enable word masks the status bits. A single level-sensitive interrupt line is raised while any enabled bit is pending. The unit watches the engine's busy flag, the FIFO occupancy counts and a write-pending indication. It also holds the receive threshold, which is written through a FIFO control word. The bus sequencing and the FIFO storage belong to other blocks.

Register access uses a one-cycle write strobe, a 2-bit register select and a 32-bit data word. The status, enable and threshold values are presented continuously on output ports.

Top module: `i2c_irq_status`

## Requirements
- R1: After synchronous reset, status, enable and threshold all read zero and the interrupt line is low.
- R2: The event bits sit at bit 31 (RX full), bit 30 (RX above threshold), bit 28 (transaction done) and bit 27 (TX underrun), in both status and enable. All other bits always read zero and ignore writes. Register select is 0 for enable, 1 for status, 2 for FIFO control, and 3 for none.
- R3: When the busy input goes from 1 to 0, bit 28 is pending after the next clock edge.
- R4: When the TX count goes from nonzero to zero while the write-pending input is 1, bit 27 is set. The same drain with write-pending at 0 sets nothing.
- R5: Bit 31 is set on every clock edge at which the RX count equals the FIFO depth (64).
- R6: A write to FIFO control loads the threshold from bits 13:8. Bit 30 is set when the RX count goes from not above the threshold to above it.
- R7: Writing the status register clears each bit written as 1 and leaves bits written as 0. Writing all ones clears every pending bit.
- R8: If an event and a clearing write hit the same bit on the same edge, the bit stays set.
- R9: Status bits latch whatever the enable holds. The interrupt line is high exactly when some bit is set in both status and enable.
- R10: A cycle with the soft reset high clears status and enable. The threshold is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst_i | input | 1 | Clears status and enable |
| busy_i | input | 1 | Engine busy flag |
| wr_pending_i | input | 1 | Write still expects more data |
| rx_count_i | input | 7 | RX FIFO occupancy |
| tx_count_i | input | 7 | TX FIFO occupancy |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| irq_o | output | 1 | Level interrupt |
| status_o | output | 32 | Status word |
| enable_o | output | 32 | Enable word |
| rx_thresh_o | output | 6 | RX threshold |

## Verification
Each event is driven both with the enable set and with the enable clear. This separates latching from interrupt masking. The TX drain is repeated with write-pending high and low to show that only a pending write raises underrun. The RX count is stepped to the threshold and then one past it, which places the threshold comparison exactly at the boundary. Clearing writes are issued both alone and on the same edge as an event, which distinguishes plain clearing from set-priority.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned BIT_RXFULL = 31;
    localparam int unsigned BIT_RXTHR  = 30;
    localparam int unsigned BIT_DONE   = 28;
    localparam int unsigned BIT_UNDER  = 27;
    localparam int unsigned THR_LSB    = 8;

    localparam logic [WORD_W-1:0] EVT_MASK =
        (32'h1 << BIT_RXFULL) | (32'h1 << BIT_RXTHR) |
        (32'h1 << BIT_DONE)   | (32'h1 << BIT_UNDER);

    typedef enum logic [1:0] {
        SEL_ENABLE  = 2'd0,
        SEL_STATUS  = 2'd1,
        SEL_FIFOCTL = 2'd2,
        SEL_NONE    = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic rx_full;
        logic rx_above;
        logic done;
        logic underrun;
    } evt_t;

    function automatic logic [WORD_W-1:0] evt_to_word(evt_t e);
        logic [WORD_W-1:0] w;
        w = '0;
        w[BIT_RXFULL] = e.rx_full;
        w[BIT_RXTHR]  = e.rx_above;
        w[BIT_DONE]   = e.done;
        w[BIT_UNDER]  = e.underrun;
        return w;
    endfunction

endpackage

// File: rtl/i2c_irq_evt.sv
module i2c_irq_evt
    import i2c_irq_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 64,
    parameter int unsigned CNT_W      = $clog2(FIFO_DEPTH + 1),
    parameter int unsigned THR_W      = 6
) (
    input  logic             clk,
    input  logic             busy_i,
    input  logic             wr_pending_i,
    input  logic [CNT_W-1:0] rx_count_i,
    input  logic [CNT_W-1:0] tx_count_i,
    input  logic [THR_W-1:0] thr_i,
    output evt_t             evt_o
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIFO_DEPTH);

    logic busy_q;
    logic above_q;
    logic tx_nz_q;
    logic above_now;
    logic tx_nz_now;

    assign above_now = rx_count_i > CNT_W'(thr_i);
    assign tx_nz_now = tx_count_i != '0;

    // History registers track their inputs in and out of reset, so an edge
    // straddling the end of reset is judged against a real sample.
    always_ff @(posedge clk) begin
        busy_q  <= busy_i;
        above_q <= above_now;
        tx_nz_q <= tx_nz_now;
    end

    always_comb begin
        evt_o.rx_full  = rx_count_i == FULL_CNT;
        evt_o.rx_above = above_now && !above_q;
        evt_o.done     = busy_q && !busy_i;
        evt_o.underrun = tx_nz_q && !tx_nz_now && wr_pending_i;
    end

endmodule

// File: rtl/i2c_irq_stat.sv
module i2c_irq_stat
    import i2c_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst_i,
    input  logic [WORD_W-1:0] set_i,
    input  logic              clr_en_i,
    input  logic [WORD_W-1:0] clr_data_i,
    output logic [WORD_W-1:0] status_o
);
    logic [WORD_W-1:0] status_q;
    logic [WORD_W-1:0] clr_mask;

    assign clr_mask = clr_en_i ? clr_data_i : '0;

    always_ff @(posedge clk) begin
        if (rst || soft_rst_i) begin
            status_q <= '0;
        end else begin
            status_q <= ((status_q & ~clr_mask) | set_i) & EVT_MASK;
        end
    end

    assign status_o = status_q;

    // R7: bits not written with 1 stay pending
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst || soft_rst_i)
        1'b1 |=> ((status_q & $past(status_q & ~clr_mask)) == $past(status_q & ~clr_mask)));

    // R8: a same-edge event beats a clearing write
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst || soft_rst_i)
        1'b1 |=> (($past(set_i & EVT_MASK) & ~status_q) == '0));

endmodule

// File: rtl/i2c_irq_cfg.sv
module i2c_irq_cfg
    import i2c_irq_pkg::*;
#(
    parameter int unsigned THR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst_i,
    input  logic              we_i,
    input  reg_sel_e          sel_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] enable_o,
    output logic [THR_W-1:0]  thr_o
);
    always_ff @(posedge clk) begin
        if (rst || soft_rst_i) begin
            enable_o <= '0;
        end else if (we_i && sel_i == SEL_ENABLE) begin
            enable_o <= wdata_i & EVT_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_o <= '0;
        end else if (we_i && sel_i == SEL_FIFOCTL) begin
            thr_o <= wdata_i[THR_LSB +: THR_W];
        end
    end

endmodule

// File: rtl/i2c_irq_status.sv
module i2c_irq_status
    import i2c_irq_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 64,
    parameter int unsigned THR_W      = 6,
    localparam int unsigned CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst_i,
    input  logic              busy_i,
    input  logic              wr_pending_i,
    input  logic [CNT_W-1:0]  rx_count_i,
    input  logic [CNT_W-1:0]  tx_count_i,
    input  logic              reg_we_i,
    input  logic [1:0]        reg_sel_i,
    input  logic [WORD_W-1:0] reg_wdata_i,
    output logic              irq_o,
    output logic [WORD_W-1:0] status_o,
    output logic [WORD_W-1:0] enable_o,
    output logic [THR_W-1:0]  rx_thresh_o
);
    reg_sel_e sel;
    evt_t     evt;
    logic     clr_en;

    assign sel    = reg_sel_e'(reg_sel_i);
    assign clr_en = reg_we_i && sel == SEL_STATUS;

    i2c_irq_evt #(
        .FIFO_DEPTH (FIFO_DEPTH),
        .CNT_W      (CNT_W),
        .THR_W      (THR_W)
    ) u_evt (
        .clk          (clk),
        .busy_i       (busy_i),
        .wr_pending_i (wr_pending_i),
        .rx_count_i   (rx_count_i),
        .tx_count_i   (tx_count_i),
        .thr_i        (rx_thresh_o),
        .evt_o        (evt)
    );

    i2c_irq_stat u_stat (
        .clk        (clk),
        .rst        (rst),
        .soft_rst_i (soft_rst_i),
        .set_i      (evt_to_word(evt)),
        .clr_en_i   (clr_en),
        .clr_data_i (reg_wdata_i),
        .status_o   (status_o)
    );

    i2c_irq_cfg #(
        .THR_W (THR_W)
    ) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .soft_rst_i (soft_rst_i),
        .we_i       (reg_we_i),
        .sel_i      (sel),
        .wdata_i    (reg_wdata_i),
        .enable_o   (enable_o),
        .thr_o      (rx_thresh_o)
    );

    assign irq_o = |(status_o & enable_o);

    // R3: completion pending one edge after busy falls
    a_r3_done_on_fall: assert property (@(posedge clk) disable iff (rst || soft_rst_i)
        $fell(busy_i) |=> status_o[BIT_DONE]);

    // R9: nothing enabled means no interrupt
    a_r9_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (enable_o == '0) |-> !irq_o);

    // R10: soft reset empties both words
    a_r10_soft_clear: assert property (@(posedge clk) disable iff (rst)
        soft_rst_i |=> (status_o == '0 && enable_o == '0));

endmodule

// File: tb/i2c_irq_status_tb.sv
module i2c_irq_status_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        soft_rst = 1'b0;
    logic        busy = 1'b0;
    logic        wr_pend = 1'b0;
    logic [6:0]  rx_cnt = '0;
    logic [6:0]  tx_cnt = '0;
    logic        we = 1'b0;
    logic [1:0]  sel = 2'd3;
    logic [31:0] wdata = '0;
    logic        irq;
    logic [31:0] status;
    logic [31:0] enable;
    logic [5:0]  thr;

    int checks = 0;
    int fails = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    i2c_irq_status u_dut (
        .clk (clk), .rst (rst), .soft_rst_i (soft_rst), .busy_i (busy),
        .wr_pending_i (wr_pend), .rx_count_i (rx_cnt), .tx_count_i (tx_cnt),
        .reg_we_i (we), .reg_sel_i (sel), .reg_wdata_i (wdata),
        .irq_o (irq), .status_o (status), .enable_o (enable), .rx_thresh_o (thr)
    );

    // Behavioural reference
    bit [31:0] m_st, m_en;
    int        m_thr;
    bit        p_busy, p_above, p_txnz;
    localparam bit [31:0] MASK = 32'hD800_0000;

    always @(posedge clk) begin
        bit above;
        bit [31:0] ev;
        above = int'(rx_cnt) > m_thr;
        ev = 0;
        if (int'(rx_cnt) == 64) ev[31] = 1;
        if (above && !p_above) ev[30] = 1;
        if (p_busy && !busy) ev[28] = 1;
        if (p_txnz && tx_cnt == 0 && wr_pend) ev[27] = 1;
        if (rst) begin
            m_st = 0; m_en = 0; m_thr = 0;
        end else begin
            if (we && sel == 2 && !rst) m_thr = int'(wdata[13:8]);
            if (soft_rst) begin
                m_st = 0; m_en = 0;
            end else begin
                if (we && sel == 1) m_st = m_st & ~wdata;
                m_st = m_st | ev;
                if (we && sel == 0) m_en = wdata & MASK;
            end
        end
        p_busy = busy; p_above = above; p_txnz = tx_cnt != 0;
    end

    always begin
        @(posedge clk);
        #5;
        checks++;
        if (status !== m_st || enable !== m_en || thr !== 6'(m_thr) ||
            irq !== |(m_st & m_en)) begin
            fails++;
            $display("FAIL %s per-cycle: status=%h en=%h thr=%0d irq=%b exp status=%h en=%h thr=%0d irq=%b",
                     cur_req, status, enable, thr, irq, m_st, m_en, m_thr, |(m_st & m_en));
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] s, logic [31:0] d);
        we = 1'b1; sel = s; wdata = d;
        @(negedge clk);
        we = 1'b0; sel = 2'd3;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        cur_req = "R1";
        chk("R1 status", status, 0); chk("R1 enable", enable, 0);
        chk("R1 thr", 32'(thr), 0); chk("R1 irq", 32'(irq), 0);

        cur_req = "R2";
        wr(2'd0, 32'hFFFF_FFFF);
        chk("R2 enable mask", enable, 32'hD800_0000);
        wr(2'd1, 32'h2000_0000);
        chk("R2 unused bit", status, 0);

        cur_req = "R3";
        busy = 1'b1; cyc(3);
        chk("R3 no early set", status, 0);
        busy = 1'b0; cyc(1);
        chk("R3 done bit", status, 32'h1000_0000);
        chk("R3 irq", 32'(irq), 1);

        cur_req = "R7";
        wr(2'd1, 32'h0000_0000);
        chk("R7 zero write", status, 32'h1000_0000);
        wr(2'd1, 32'h1000_0000);
        chk("R7 cleared", status, 0);
        chk("R7 irq low", 32'(irq), 0);

        cur_req = "R9";
        wr(2'd0, 32'h0);
        busy = 1'b1; cyc(2); busy = 1'b0; cyc(1);
        chk("R9 latched while masked", status, 32'h1000_0000);
        chk("R9 irq masked", 32'(irq), 0);
        wr(2'd0, 32'h1000_0000);
        chk("R9 irq enabled", 32'(irq), 1);
        wr(2'd1, 32'hFFFF_FFFF);

        cur_req = "R4";
        wr_pend = 1'b1; tx_cnt = 7'd5; cyc(2);
        tx_cnt = 7'd0; cyc(1);
        chk("R4 underrun", status, 32'h0800_0000);
        wr(2'd1, 32'hFFFF_FFFF);
        wr_pend = 1'b0; tx_cnt = 7'd3; cyc(2);
        tx_cnt = 7'd0; cyc(2);
        chk("R4 no underrun without pending write", status, 0);

        cur_req = "R6";
        wr(2'd2, 32'h0000_0A00);
        chk("R6 thr loaded", 32'(thr), 10);
        rx_cnt = 7'd10; cyc(2);
        chk("R6 at threshold", status, 0);
        rx_cnt = 7'd11; cyc(1);
        chk("R6 above threshold", status, 32'h4000_0000);
        wr(2'd1, 32'h4000_0000);
        cyc(2);
        chk("R6 no retrigger while above", status, 0);

        cur_req = "R5";
        rx_cnt = 7'd64; cyc(1);
        chk("R5 full", status, 32'h8000_0000);

        cur_req = "R8";
        wr(2'd1, 32'hFFFF_FFFF);
        chk("R8 full stays on clear", status, 32'h8000_0000);
        rx_cnt = 7'd0; cyc(1);
        busy = 1'b1; cyc(1);
        we = 1'b1; sel = 2'd1; wdata = 32'hFFFF_FFFF; busy = 1'b0;
        @(negedge clk);
        we = 1'b0; sel = 2'd3;
        chk("R8 done wins over clear", status, 32'h1000_0000);

        cur_req = "R10";
        wr(2'd0, 32'hFFFF_FFFF);
        soft_rst = 1'b1; cyc(1); soft_rst = 1'b0;
        chk("R10 status", status, 0);
        chk("R10 enable", enable, 0);
        chk("R10 thr kept", 32'(thr), 10);
        cyc(3);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule